// File: doc/BRIEF.md
# Interleaved Multithread Register File and Issue Selector

This block stores the architectural registers of a barrel-style multithreaded core and decides which hardware thread issues each cycle. Every thread owns a private set of registers. The register storage is two identical one-read/one-write RAMs. Both RAMs receive the same write, so the block has one write port and two independent read ports. The RAM address is the thread number with the register index appended below it.

An issue selector scans the threads in round-robin order. It starts at the thread after the one that issued most recently. It never picks the thread that issued in the cycle just before, and it never picks a thread whose ready flag is low. When no thread qualifies it issues a bubble. Because one thread can never occupy two adjacent slots, a thread's result is always written back before that thread reads its operands again. The datapath therefore has no forwarding or hazard logic. Writeback uses the thread number that travelled down the pipeline with the instruction, not the thread that is issuing now.

Top module: `mt_regfile`

## Requirements
- R1: After a synchronous active-low reset, `issue_valid` is 0 and the round-robin pointer rests on the last thread. The first issue therefore goes to the lowest-numbered eligible thread.
- R2: The same thread is never issued in two consecutive cycles.
- R3: With every thread ready, threads issue in ascending cyclic order 0,1,...,N-1,0 without gaps.
- R4: The issue decision is registered. A thread issued in cycle k had its ready flag high at the clock edge that starts cycle k, and not-ready threads are skipped in the scan.
- R5: When no ready thread other than the one issued in the previous cycle exists, the cycle is a bubble (`issue_valid` = 0). A single ready thread therefore issues every other cycle.
- R6: A write with `wr_en` = 1 to thread t, register i is returned on a read port whose registered read address is {t, i}. Read data appears one cycle after the read address is presented.
- R7: Registers of different threads with the same index are independent.
- R8: Both read ports return data from the same written contents, each for its own index.
- R9: A read and a write to the same address at the same clock edge return the value held before the write.
- R10: With `wr_en` = 0, the stored contents are unchanged whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_ready | input | NUM_THREADS | Per-thread ready flags |
| issue_valid | output | 1 | A thread issues this cycle (0 = bubble) |
| issue_tid | output | TID_W | Thread issuing this cycle |
| rd_tid | input | TID_W | Thread whose registers are read |
| rd_a_idx | input | IDX_W | Register index for read port A |
| rd_b_idx | input | IDX_W | Register index for read port B |
| rd_a_data | output | DATA_W | Port A data, one cycle after the address |
| rd_b_data | output | DATA_W | Port B data, one cycle after the address |
| wr_en | input | 1 | Writeback enable |
| wr_tid | input | TID_W | Thread carried with the retiring instruction |
| wr_idx | input | IDX_W | Destination register index |
| wr_data | input | DATA_W | Writeback value |

## Verification
The selector is driven with all threads ready, with alternate threads ready, with one ready thread, with none ready, and with a changing pattern. These cases separate, in turn, plain rotation, skipping of idle threads, enforced bubbles from the adjacency rule, and bubbles from an empty ready set. The register file is filled with values that encode thread and index. It is then read back through both ports with different indices, which exposes address aliasing between threads and any mismatch between the two copies. A write and a read to the same address on one edge, and a write attempt with the enable low, distinguish read-before-write ordering and enable gating from plain storage.

// File: rtl/mtrf_pkg.sv
// Shared types and helpers for the multithread register file.
// Assumes at most 64 hardware threads.
package mtrf_pkg;

    localparam int unsigned MAX_THREADS = 64;

    typedef struct packed {
        logic       found;
        logic [5:0] tid;
    } rr_pick_t;

    // Round-robin scan: first set bit of elig after position ptr, wrapping at n.
    function automatic rr_pick_t rr_pick(input logic [MAX_THREADS-1:0] elig,
                                         input int unsigned ptr,
                                         input int unsigned n);
        rr_pick_t r;
        r.found = 1'b0;
        r.tid   = '0;
        for (int unsigned i = 1; i <= MAX_THREADS; i++) begin
            if (i <= n) begin
                int unsigned c;
                logic [5:0]  c6;
                c  = (ptr + i) % n;
                c6 = c[5:0];
                if (!r.found && elig[c6]) begin
                    r.found = 1'b1;
                    r.tid   = c6;
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mtrf_sched.sv
// Round-robin thread issue selector.
// Picks, at each edge, the first ready thread after the last issued one,
// excluding the thread issued in the cycle just ending. Emits a bubble
// when none qualifies. Assumes NUM_THREADS between 2 and 64.
module mtrf_sched #(
    parameter int unsigned NUM_THREADS = 4,
    localparam int unsigned TID_W = $clog2(NUM_THREADS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] thr_ready,
    output logic                   issue_valid,
    output logic [TID_W-1:0]       issue_tid
);
    import mtrf_pkg::*;

    logic [TID_W-1:0]       last_tid;
    logic [NUM_THREADS-1:0] block_mask;
    logic [NUM_THREADS-1:0] elig;
    rr_pick_t               pick;

    // Mask out the thread occupying the current slot.
    always_comb begin
        block_mask = '0;
        if (issue_valid) block_mask[issue_tid] = 1'b1;
        elig = thr_ready & ~block_mask;
        pick = rr_pick(MAX_THREADS'(elig), int'(last_tid), NUM_THREADS);
    end

    // Register the issue decision and advance the round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_valid <= 1'b0;
            issue_tid   <= '0;
            last_tid    <= TID_W'(NUM_THREADS - 1);
        end else begin
            issue_valid <= pick.found;
            if (pick.found) begin
                issue_tid <= pick.tid[TID_W-1:0];
                last_tid  <= pick.tid[TID_W-1:0];
            end
        end
    end

endmodule

// File: rtl/mtrf_ram.sv
// One-read/one-write RAM with registered read.
// A read and a write to the same address on one edge return the old word.
// No reset on contents.
module mtrf_ram #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Write port and read-before-write registered read port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/mt_regfile.sv
// Banked multithread register file with round-robin issue selector.
// Two RAM copies share one write port to give two read ports; the address
// is {thread, index}. Assumes NUM_THREADS and NUM_REGS are powers of two.
module mt_regfile #(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned NUM_REGS    = 16,
    parameter int unsigned DATA_W      = 32,
    localparam int unsigned TID_W  = $clog2(NUM_THREADS),
    localparam int unsigned IDX_W  = $clog2(NUM_REGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] thr_ready,
    output logic                   issue_valid,
    output logic [TID_W-1:0]       issue_tid,
    input  logic [TID_W-1:0]       rd_tid,
    input  logic [IDX_W-1:0]       rd_a_idx,
    input  logic [IDX_W-1:0]       rd_b_idx,
    output logic [DATA_W-1:0]      rd_a_data,
    output logic [DATA_W-1:0]      rd_b_data,
    input  logic                   wr_en,
    input  logic [TID_W-1:0]       wr_tid,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [DATA_W-1:0]      wr_data
);
    localparam int unsigned DEPTH  = NUM_THREADS * NUM_REGS;
    localparam int unsigned ADDR_W = TID_W + IDX_W;
    localparam int unsigned NUM_RD = 2;

    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr [NUM_RD];
    logic [DATA_W-1:0] rd_word [NUM_RD];

    // Form RAM addresses from thread number and register index.
    always_comb begin
        wr_addr    = {wr_tid, wr_idx};
        rd_addr[0] = {rd_tid, rd_a_idx};
        rd_addr[1] = {rd_tid, rd_b_idx};
    end

    mtrf_sched #(.NUM_THREADS(NUM_THREADS)) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .thr_ready   (thr_ready),
        .issue_valid (issue_valid),
        .issue_tid   (issue_tid)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_bank
        mtrf_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
            .clk   (clk),
            .we    (wr_en),
            .waddr (wr_addr),
            .wdata (wr_data),
            .raddr (rd_addr[p]),
            .rdata (rd_word[p])
        );
    end

    assign rd_a_data = rd_word[0];
    assign rd_b_data = rd_word[1];

endmodule

// File: rtl/mt_regfile_chk.sv
// Assertion checker for mt_regfile, attached by bind.
module mt_regfile_chk #(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned NUM_REGS    = 16,
    parameter int unsigned DATA_W      = 32,
    localparam int unsigned TID_W  = $clog2(NUM_THREADS),
    localparam int unsigned IDX_W  = $clog2(NUM_REGS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_THREADS-1:0] thr_ready,
    input logic                   issue_valid,
    input logic [TID_W-1:0]       issue_tid,
    input logic [TID_W-1:0]       rd_tid,
    input logic [IDX_W-1:0]       rd_a_idx,
    input logic [IDX_W-1:0]       rd_b_idx,
    input logic [DATA_W-1:0]      rd_a_data,
    input logic [DATA_W-1:0]      rd_b_data,
    input logic                   wr_en,
    input logic [TID_W-1:0]       wr_tid,
    input logic [IDX_W-1:0]       wr_idx,
    input logic [DATA_W-1:0]      wr_data
);
    localparam int unsigned AW = TID_W + IDX_W;

    logic                   live_q;
    logic [NUM_THREADS-1:0] rdy_q;
    logic                   pv_q;
    logic [TID_W-1:0]       pt_q;
    logic [NUM_THREADS-1:0] blk;
    logic [NUM_THREADS-1:0] elig;
    logic [AW-1:0]          ra_a, ra_b, wa;

    // Capture inputs and issue state from the previous edge.
    always_ff @(posedge clk) begin
        live_q <= rst_n;
        rdy_q  <= thr_ready;
        pv_q   <= issue_valid;
        pt_q   <= issue_tid;
    end

    // Threads that were allowed to issue at the previous edge.
    always_comb begin
        blk = '0;
        if (pv_q) blk[pt_q] = 1'b1;
        elig = rdy_q & ~blk;
        ra_a = {rd_tid, rd_a_idx};
        ra_b = {rd_tid, rd_b_idx};
        wa   = {wr_tid, wr_idx};
    end

    a_r2_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && issue_valid && pv_q) |-> (issue_tid != pt_q));

    a_r4_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && issue_valid) |-> rdy_q[issue_tid]);

    a_r5_bubble_iff_none: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (issue_valid == (elig != '0)));

    a_r6_write_seen_a: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en, 2) && ($past(ra_a) == $past(wa, 2))
         && !($past(wr_en) && ($past(wa) == $past(ra_a))))
        |-> (rd_a_data == $past(wr_data, 2)));

    a_r8_write_seen_b: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en, 2) && ($past(ra_b) == $past(wa, 2))
         && !($past(wr_en) && ($past(wa) == $past(ra_b))))
        |-> (rd_b_data == $past(wr_data, 2)));

endmodule

bind mt_regfile mt_regfile_chk #(
    .NUM_THREADS (NUM_THREADS),
    .NUM_REGS    (NUM_REGS),
    .DATA_W      (DATA_W)
) u_chk (.*);

// File: tb/mt_regfile_bench.sv
// Directed bench for mt_regfile: one task per scenario.
module mt_regfile_bench;
    localparam int unsigned NT = 4;
    localparam int unsigned NR = 16;
    localparam int unsigned DW = 32;
    localparam int unsigned TW = $clog2(NT);
    localparam int unsigned IW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] thr_ready = '0;
    logic          issue_valid;
    logic [TW-1:0] issue_tid;
    logic [TW-1:0] rd_tid = '0;
    logic [IW-1:0] rd_a_idx = '0, rd_b_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data;
    logic          wr_en = 1'b0;
    logic [TW-1:0] wr_tid = '0;
    logic [IW-1:0] wr_idx = '0;
    logic [DW-1:0] wr_data = '0;

    int checks = 0;
    int fails  = 0;

    // Reference of the issue rule, built from R1..R5.
    logic          m_valid = 1'b0;
    logic [TW-1:0] m_tid = '0;
    logic [TW-1:0] m_ptr = TW'(NT - 1);
    logic [DW-1:0] shadow [NT][NR];

    always #10 clk = ~clk;

    mt_regfile #(.NUM_THREADS(NT), .NUM_REGS(NR), .DATA_W(DW)) u_mt_regfile (
        .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready),
        .issue_valid(issue_valid), .issue_tid(issue_tid),
        .rd_tid(rd_tid), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_tid(wr_tid), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step(input logic [NT-1:0] rdy);
        logic found;
        logic [TW-1:0] pick;
        found = 1'b0;
        pick  = '0;
        for (int i = 1; i <= NT; i++) begin
            logic [TW-1:0] c;
            c = TW'((int'(m_ptr) + i) % NT);
            if (!found && rdy[c] && !(m_valid && m_tid == c)) begin
                found = 1'b1;
                pick  = c;
            end
        end
        m_valid = found;
        if (found) begin
            m_tid = pick;
            m_ptr = pick;
        end
    endtask

    // One clock: advance the reference alongside the design, then settle.
    task automatic tick();
        logic [NT-1:0] r;
        r = thr_ready;
        @(posedge clk);
        if (rst_n) model_step(r);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        m_valid = 1'b0; m_tid = '0; m_ptr = TW'(NT - 1);
        check(issue_valid == 1'b0, "R1 reset valid", DW'(issue_valid), 0);
        thr_ready = '1;
        tick();
        check(issue_valid && issue_tid == 0, "R1 first issue thread0",
              DW'({issue_valid, issue_tid}), DW'({1'b1, TW'(0)}));
    endtask

    task automatic t_sched(input logic [NT-1:0] rdy, input int cycles, input string req);
        logic          pv;
        logic [TW-1:0] pt;
        thr_ready = rdy;
        for (int k = 0; k < cycles; k++) begin
            pv = issue_valid;
            pt = issue_tid;
            tick();
            check(issue_valid == m_valid && (!m_valid || issue_tid == m_tid), req,
                  DW'({issue_valid, issue_tid}), DW'({m_valid, m_tid}));
            check(!(pv && issue_valid && pt == issue_tid), "R2 adjacent same thread",
                  DW'(issue_tid), DW'(pt));
        end
    endtask

    task automatic t_rotation();
        // R3: all ready, expect consecutive ascending threads without gaps.
        logic [TW-1:0] prev;
        thr_ready = '1;
        tick();
        prev = issue_tid;
        for (int k = 0; k < 2 * NT; k++) begin
            tick();
            check(issue_valid && issue_tid == TW'(prev + 1), "R3 rotation",
                  DW'(issue_tid), DW'(TW'(prev + 1)));
            prev = issue_tid;
        end
    endtask

    task automatic t_single();
        // R5: only thread 2 ready, expect issue/bubble alternation.
        int issued;
        issued = 0;
        thr_ready = NT'(4);
        tick();
        for (int k = 0; k < 8; k++) begin
            tick();
            if (issue_valid) issued++;
        end
        check(issued == 4, "R5 single thread half rate", DW'(issued), 4);
    endtask

    task automatic wr(input int t, input int i, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_tid = TW'(t); wr_idx = IW'(i); wr_data = d;
        tick();
        wr_en = 1'b0;
        shadow[t][i] = d;
    endtask

    task automatic rd(input int t, input int a, input int b, input string req);
        rd_tid = TW'(t); rd_a_idx = IW'(a); rd_b_idx = IW'(b);
        tick();
        check(rd_a_data == shadow[t][a], req, rd_a_data, shadow[t][a]);
        check(rd_b_data == shadow[t][b], req, rd_b_data, shadow[t][b]);
    endtask

    task automatic t_fill();
        thr_ready = '0;
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < NR; i++)
                wr(t, i, 32'hA500_0000 | DW'(t << 8) | DW'(i));
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < NR; i++)
                rd(t, i, NR - 1 - i, "R6 R7 R8 readback");
    endtask

    task automatic t_rdw();
        // R9: same-edge read and write of thread 1 reg 5 returns old word.
        logic [DW-1:0] old_v;
        old_v = shadow[1][5];
        rd_tid = 1; rd_a_idx = 5; rd_b_idx = 5;
        wr_en = 1'b1; wr_tid = 1; wr_idx = 5; wr_data = 32'h1234_5678;
        tick();
        wr_en = 1'b0;
        check(rd_a_data == old_v, "R9 read before write A", rd_a_data, old_v);
        check(rd_b_data == old_v, "R9 read before write B", rd_b_data, old_v);
        shadow[1][5] = 32'h1234_5678;
        rd(1, 5, 5, "R9 new value next read");
    endtask

    task automatic t_noen();
        // R10: write inputs toggle with enable low; contents unchanged.
        wr_en = 1'b0; wr_tid = 3; wr_idx = 9; wr_data = 32'hDEAD_BEEF;
        tick();
        wr_tid = 0; wr_idx = 0;
        tick();
        rd(3, 9, 0, "R10 disabled write ignored");
        rd(0, 0, 9, "R10 disabled write ignored");
        wr_tid = 3; wr_idx = 9; wr_data = 32'h0;
    endtask

    initial begin
        #4_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_rotation();
        t_sched('1, 10, "R3 all ready");
        t_sched(NT'(4'b1010), 10, "R4 skip not ready");
        t_single();
        t_sched(NT'(4'b0100), 6, "R5 single ready");
        t_sched('0, 4, "R5 none ready");
        t_sched(NT'(4'b0011), 6, "R4 pair ready");
        t_sched(NT'(4'b1001), 6, "R4 wrap ready");
        t_fill();
        t_rdw();
        t_noen();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule